// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns an operand reference into a 20-bit physical memory address. It builds a 16-bit offset from up to three terms: a base register (BX or BP), an index register (SI or DI) and a displacement. A mode code picks which of those terms are added. The block then chooses a segment register, either by the default rules or by an explicit override. It shifts the segment value left by four bits and adds the offset to it.

The block also drives the bank controls of a 16-bit data bus. That bus is split into an even byte bank on lines 7..0 and an odd byte bank on lines 15..8. A word access that starts at an odd address is flagged as misaligned, because the bus needs two transfers for it.

The request is sampled on a clock edge, and the result appears one cycle later together with a valid strobe. Between requests the result stays where it was.

Top module: `seg_addr_gen`

## Requirements
- R1: `paddr_o` equals (segment value × 16 + offset) modulo 2^20, where the segment value is the content of the selected segment register.
- R2: `mode_i` selects the offset terms: 0 = displacement only, 1 = base only, 2 = index only, 3 = base + displacement, 4 = index + displacement, 5 = base + index, 6 = base + index + displacement, 7 = displacement only.
- R3: `base_sel_i` = 0 selects BX as the base and 1 selects BP. `index_sel_i` = 0 selects SI as the index and 1 selects DI.
- R4: When `disp_wide_i` = 0, only `disp_i[7:0]` is used, and it is sign-extended to 16 bits. When `disp_wide_i` = 1, all 16 bits of `disp_i` are used. The offset sum wraps modulo 2^16 before the segment is added.
- R5: With no override and no string destination, the segment is DS, except in modes that use a base with BP selected, where it is SS. `seg_sel_o` encodes ES = 0, CS = 1, SS = 2, DS = 3.
- R6: With no override, `str_dst_i` = 1 selects ES, whatever the mode.
- R7: `ovr_en_i` = 1 selects the segment coded on `ovr_seg_i` (same encoding as R5), whatever the other inputs are.
- R8: `bhe_n_o` is 1 only for a byte access (`word_i` = 0) at an even address. In every other case it is 0.
- R9: `misalign_o` is 1 exactly when `word_i` = 1 and `paddr_o[0]` = 1.
- R10: `valid_o` is 1 in the cycle after a clock edge that saw `req_i` = 1. After an edge with `req_i` = 0, `valid_o` is 0 and the other outputs keep their values.
- R11: During and right after reset, `valid_o` = 0, `paddr_o` = 0, `bhe_n_o` = 1, `misalign_o` = 0 and `seg_sel_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Request strobe |
| mode_i | input | 3 | Offset-form code |
| base_sel_i | input | 1 | Base register choice (0 BX, 1 BP) |
| index_sel_i | input | 1 | Index register choice (0 SI, 1 DI) |
| disp_wide_i | input | 1 | Displacement width (0 short, 1 full) |
| disp_i | input | 16 | Displacement |
| bx_i | input | 16 | BX value |
| bp_i | input | 16 | BP value |
| si_i | input | 16 | SI value |
| di_i | input | 16 | DI value |
| cs_i | input | 16 | CS value |
| ds_i | input | 16 | DS value |
| es_i | input | 16 | ES value |
| ss_i | input | 16 | SS value |
| ovr_en_i | input | 1 | Segment override request |
| ovr_seg_i | input | 2 | Override segment code |
| str_dst_i | input | 1 | String destination reference |
| word_i | input | 1 | Word (1) or byte (0) access |
| valid_o | output | 1 | Result valid |
| paddr_o | output | 20 | Physical address |
| bhe_n_o | output | 1 | Odd-bank enable, active low |
| misalign_o | output | 1 | Word at odd address |
| seg_sel_o | output | 2 | Segment actually used |

## Verification
Each of the eight mode codes is driven with distinct register values, so that a term added wrongly or left out changes the address. The BX/BP and SI/DI choices are crossed with those values for the same reason. Displacements of 0x80 and 0xFF in short form tell sign extension apart from zero extension. A case where base plus displacement passes 0xFFFF, and a case with segment 0xFFFF plus a large offset, tell the 16-bit and 20-bit wraps apart from wider arithmetic.

The segment choice is tested with BP as base, with a string destination, and with an override placed on top of each of these, which exposes the priority order. All four byte/word and even/odd combinations are driven to check the bank enable and the misaligned flag. Cycles with the request low and the inputs changed show that the outputs hold.

// File: rtl/seg_addr_pkg.sv
// Package: shared encodings for the segmented address generator.
// Assumes: the segment code order matches the override input encoding.
package seg_addr_pkg;
    typedef enum logic [2:0] {
        AM_DISP           = 3'd0,
        AM_BASE           = 3'd1,
        AM_INDEX          = 3'd2,
        AM_BASE_DISP      = 3'd3,
        AM_INDEX_DISP     = 3'd4,
        AM_BASE_INDEX     = 3'd5,
        AM_BASE_INDEX_DISP = 3'd6,
        AM_RSVD           = 3'd7
    } addr_mode_e;

    typedef enum logic [1:0] {
        SEG_ES = 2'd0,
        SEG_CS = 2'd1,
        SEG_SS = 2'd2,
        SEG_DS = 2'd3
    } seg_code_e;
endpackage

// File: rtl/sea_offset.sv
// Module: sea_offset
// Builds the 16-bit offset from base, index and displacement per mode.
// Assumes: OFF_W > SDISP_W; all sums wrap modulo 2^OFF_W.
module sea_offset
    import seg_addr_pkg::*;
#(
    parameter int OFF_W   = 16,
    parameter int SDISP_W = 8
) (
    input  logic [2:0]       mode,
    input  logic             base_sel,
    input  logic             index_sel,
    input  logic             disp_wide,
    input  logic [OFF_W-1:0] disp,
    input  logic [OFF_W-1:0] bx,
    input  logic [OFF_W-1:0] bp,
    input  logic [OFF_W-1:0] si,
    input  logic [OFF_W-1:0] di,
    output logic [OFF_W-1:0] offset,
    output logic             uses_bp
);
    localparam int EXT_W = OFF_W - SDISP_W;

    logic [OFF_W-1:0] base_v, idx_v, disp_v;
    logic             use_base, use_idx, use_disp;

    // Pick register operands and widen the displacement.
    always_comb begin
        base_v = base_sel  ? bp : bx;
        idx_v  = index_sel ? di : si;
        disp_v = disp_wide ? disp
                           : {{EXT_W{disp[SDISP_W-1]}}, disp[SDISP_W-1:0]};
    end

    // Decode which terms the mode adds.
    always_comb begin
        use_base = 1'b0;
        use_idx  = 1'b0;
        use_disp = 1'b0;
        case (addr_mode_e'(mode))
            AM_DISP:            use_disp = 1'b1;
            AM_BASE:            use_base = 1'b1;
            AM_INDEX:           use_idx  = 1'b1;
            AM_BASE_DISP:       begin use_base = 1'b1; use_disp = 1'b1; end
            AM_INDEX_DISP:      begin use_idx  = 1'b1; use_disp = 1'b1; end
            AM_BASE_INDEX:      begin use_base = 1'b1; use_idx  = 1'b1; end
            AM_BASE_INDEX_DISP: begin use_base = 1'b1; use_idx = 1'b1; use_disp = 1'b1; end
            default:            use_disp = 1'b1;
        endcase
    end

    // Sum the selected terms, truncated to the offset width.
    always_comb begin
        offset  = (use_base ? base_v : '0) + (use_idx ? idx_v : '0)
                + (use_disp ? disp_v : '0);
        uses_bp = use_base & base_sel;
    end
endmodule

// File: rtl/sea_segsel.sv
// Module: sea_segsel
// Chooses the segment register: override, then string destination,
// then BP-based stack default, then DS.
// Assumes: override codes use seg_code_e encoding.
module sea_segsel
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = 16
) (
    input  logic             uses_bp,
    input  logic             str_dst,
    input  logic             ovr_en,
    input  logic [1:0]       ovr_seg,
    input  logic [SEG_W-1:0] cs,
    input  logic [SEG_W-1:0] ds,
    input  logic [SEG_W-1:0] es,
    input  logic [SEG_W-1:0] ss,
    output logic [1:0]       seg_code,
    output logic [SEG_W-1:0] seg_val
);
    // Apply the priority order to pick the segment code.
    always_comb begin
        if (ovr_en)       seg_code = ovr_seg;
        else if (str_dst) seg_code = SEG_ES;
        else if (uses_bp) seg_code = SEG_SS;
        else              seg_code = SEG_DS;
    end

    // Fetch the value of the chosen segment register.
    always_comb begin
        case (seg_code_e'(seg_code))
            SEG_ES:  seg_val = es;
            SEG_CS:  seg_val = cs;
            SEG_SS:  seg_val = ss;
            default: seg_val = ds;
        endcase
    end
endmodule

// File: rtl/sea_phys.sv
// Module: sea_phys
// Forms the physical address and the bank controls.
// Assumes: OFF_W <= SEG_W + SHIFT; result wraps modulo 2^(SEG_W+SHIFT).
module sea_phys #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4
) (
    input  logic [SEG_W-1:0]       seg_val,
    input  logic [OFF_W-1:0]       offset,
    input  logic                   word,
    output logic [SEG_W+SHIFT-1:0] paddr,
    output logic                   bhe_n,
    output logic                   misalign
);
    localparam int PA_W = SEG_W + SHIFT;
    localparam int PAD_W = PA_W - OFF_W;

    logic [PA_W-1:0] seg_sh, off_ext;

    // Shift the segment and zero-extend the offset.
    always_comb begin
        seg_sh  = {seg_val, {SHIFT{1'b0}}};
        off_ext = {{PAD_W{1'b0}}, offset};
    end

    // Add, and derive the bank enable and the misaligned flag from bit 0.
    always_comb begin
        paddr    = seg_sh + off_ext;
        bhe_n    = ~(paddr[0] | word);
        misalign = paddr[0] & word;
    end
endmodule

// File: rtl/seg_addr_gen.sv
// Module: seg_addr_gen (top)
// Registers the physical address, the bank controls and the segment code
// one cycle after a request.
// Assumes: synchronous active-low reset; outputs hold between requests.
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int SEG_W   = 16,
    parameter int OFF_W   = 16,
    parameter int SHIFT   = 4,
    parameter int SDISP_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_i,
    input  logic [2:0]  mode_i,
    input  logic        base_sel_i,
    input  logic        index_sel_i,
    input  logic        disp_wide_i,
    input  logic [15:0] disp_i,
    input  logic [15:0] bx_i,
    input  logic [15:0] bp_i,
    input  logic [15:0] si_i,
    input  logic [15:0] di_i,
    input  logic [15:0] cs_i,
    input  logic [15:0] ds_i,
    input  logic [15:0] es_i,
    input  logic [15:0] ss_i,
    input  logic        ovr_en_i,
    input  logic [1:0]  ovr_seg_i,
    input  logic        str_dst_i,
    input  logic        word_i,
    output logic        valid_o,
    output logic [19:0] paddr_o,
    output logic        bhe_n_o,
    output logic        misalign_o,
    output logic [1:0]  seg_sel_o
);
    localparam int PA_W = SEG_W + SHIFT;

    logic [OFF_W-1:0] offset_c;
    logic             uses_bp_c;
    logic [1:0]       seg_code_c;
    logic [SEG_W-1:0] seg_val_c;
    logic [PA_W-1:0]  paddr_c;
    logic             bhe_n_c, misalign_c;

    sea_offset #(.OFF_W(OFF_W), .SDISP_W(SDISP_W)) u_offset (
        .mode(mode_i), .base_sel(base_sel_i), .index_sel(index_sel_i),
        .disp_wide(disp_wide_i), .disp(disp_i),
        .bx(bx_i), .bp(bp_i), .si(si_i), .di(di_i),
        .offset(offset_c), .uses_bp(uses_bp_c)
    );

    sea_segsel #(.SEG_W(SEG_W)) u_segsel (
        .uses_bp(uses_bp_c), .str_dst(str_dst_i), .ovr_en(ovr_en_i),
        .ovr_seg(ovr_seg_i), .cs(cs_i), .ds(ds_i), .es(es_i), .ss(ss_i),
        .seg_code(seg_code_c), .seg_val(seg_val_c)
    );

    sea_phys #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_phys (
        .seg_val(seg_val_c), .offset(offset_c), .word(word_i),
        .paddr(paddr_c), .bhe_n(bhe_n_c), .misalign(misalign_c)
    );

    // Output stage: capture the result on a request, else hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o    <= 1'b0;
            paddr_o    <= '0;
            bhe_n_o    <= 1'b1;
            misalign_o <= 1'b0;
            seg_sel_o  <= '0;
        end else begin
            valid_o <= req_i;
            if (req_i) begin
                paddr_o    <= paddr_c;
                bhe_n_o    <= bhe_n_c;
                misalign_o <= misalign_c;
                seg_sel_o  <= seg_code_c;
            end
        end
    end

    assert_valid_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o == $past(req_i));
    assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_i) |-> ($stable(paddr_o) && $stable(seg_sel_o)));
    assert_misalign_drives_high_bank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_o |-> !bhe_n_o);
    assert_even_byte_low_bank_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_i) && !$past(word_i) && !paddr_o[0]) |-> bhe_n_o);
    assert_override_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_i) && $past(ovr_en_i)) |-> seg_sel_o == $past(ovr_seg_i));
    assert_string_dest_es_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_i) && !$past(ovr_en_i) && $past(str_dst_i)) |-> seg_sel_o == 2'd0);
endmodule

// File: tb/seg_addr_gen_tb.sv
// Bench: behavioural reference model updated on every clock and compared
// with the design at each falling edge.
module seg_addr_gen_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [2:0]  mode_i = '0;
    logic        base_sel_i = 1'b0, index_sel_i = 1'b0, disp_wide_i = 1'b0;
    logic [15:0] disp_i = '0, bx_i = '0, bp_i = '0, si_i = '0, di_i = '0;
    logic [15:0] cs_i = '0, ds_i = '0, es_i = '0, ss_i = '0;
    logic        ovr_en_i = 1'b0;
    logic [1:0]  ovr_seg_i = '0;
    logic        str_dst_i = 1'b0, word_i = 1'b0;
    logic        valid_o, bhe_n_o, misalign_o;
    logic [19:0] paddr_o;
    logic [1:0]  seg_sel_o;

    int n_tests = 0;
    int n_fail  = 0;
    string tag = "R11";

    int exp_valid = 0, exp_pa = 0, exp_bhe = 1, exp_mis = 0, exp_seg = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .mode_i(mode_i),
        .base_sel_i(base_sel_i), .index_sel_i(index_sel_i),
        .disp_wide_i(disp_wide_i), .disp_i(disp_i),
        .bx_i(bx_i), .bp_i(bp_i), .si_i(si_i), .di_i(di_i),
        .cs_i(cs_i), .ds_i(ds_i), .es_i(es_i), .ss_i(ss_i),
        .ovr_en_i(ovr_en_i), .ovr_seg_i(ovr_seg_i), .str_dst_i(str_dst_i),
        .word_i(word_i), .valid_o(valid_o), .paddr_o(paddr_o),
        .bhe_n_o(bhe_n_o), .misalign_o(misalign_o), .seg_sel_o(seg_sel_o)
    );

    // Reference model: recompute from the requirements at each rising edge.
    always @(posedge clk) begin
        int b, x, d, off, sc, sv;
        bit ub, ui, ud;
        if (!rst_n) begin
            exp_valid = 0; exp_pa = 0; exp_bhe = 1; exp_mis = 0; exp_seg = 0;
        end else begin
            exp_valid = req_i;
            if (req_i) begin
                ub = mode_i inside {3'd1, 3'd3, 3'd5, 3'd6};
                ui = mode_i inside {3'd2, 3'd4, 3'd5, 3'd6};
                ud = mode_i inside {3'd0, 3'd3, 3'd4, 3'd6, 3'd7};
                b = base_sel_i ? int'(bp_i) : int'(bx_i);
                x = index_sel_i ? int'(di_i) : int'(si_i);
                if (disp_wide_i) d = int'(disp_i);
                else d = (disp_i[7:0] >= 8'h80) ? int'(disp_i[7:0]) - 256 : int'(disp_i[7:0]);
                off = ((ub ? b : 0) + (ui ? x : 0) + (ud ? d : 0)) & 32'hFFFF;
                if (ovr_en_i) sc = int'(ovr_seg_i);
                else if (str_dst_i) sc = 0;
                else if (ub && base_sel_i) sc = 2;
                else sc = 3;
                case (sc)
                    0: sv = int'(es_i);
                    1: sv = int'(cs_i);
                    2: sv = int'(ss_i);
                    default: sv = int'(ds_i);
                endcase
                exp_pa  = (sv * 16 + off) % 1048576;
                exp_seg = sc;
                exp_bhe = (!word_i && (exp_pa % 2 == 0)) ? 1 : 0;
                exp_mis = (word_i && (exp_pa % 2 == 1)) ? 1 : 0;
            end
        end
    end

    task automatic chk(string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // Compare every output away from the active edge.
    always @(negedge clk) begin
        chk("valid", int'(valid_o), exp_valid);
        chk("paddr", int'(paddr_o), exp_pa);
        chk("bhe_n", int'(bhe_n_o), exp_bhe);
        chk("misalign", int'(misalign_o), exp_mis);
        chk("seg_sel", int'(seg_sel_o), exp_seg);
    end

    // Drive one request on the falling edge; the result is checked one cycle later.
    task automatic issue(string t, logic [2:0] m, logic bs, logic is, logic dw,
                         logic [15:0] d, logic w, logic oe, logic [1:0] os, logic sd);
        @(negedge clk);
        #1;
        tag = t; req_i = 1'b1; mode_i = m; base_sel_i = bs; index_sel_i = is;
        disp_wide_i = dw; disp_i = d; word_i = w; ovr_en_i = oe; ovr_seg_i = os;
        str_dst_i = sd;
    endtask

    task automatic idle(string t);
        @(negedge clk);
        #1;
        tag = t; req_i = 1'b0;
        mode_i = ~mode_i; disp_i = ~disp_i; word_i = ~word_i; ovr_en_i = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bx_i = 16'h1000; bp_i = 16'h2200; si_i = 16'h0030; di_i = 16'h0405;
        cs_i = 16'h1111; ds_i = 16'h2000; es_i = 16'h3000; ss_i = 16'h4000;
        repeat (3) @(negedge clk);      // R11: reset values are checked at each falling edge
        rst_n = 1'b1;
        // R2 / R3: every mode code with both register choices
        for (int m = 0; m < 8; m++) begin
            issue("R2", 3'(m), 1'b0, 1'b0, 1'b1, 16'h0123, 1'b0, 1'b0, 2'd0, 1'b0);
            issue("R3", 3'(m), 1'b1, 1'b1, 1'b1, 16'h0040, 1'b0, 1'b0, 2'd0, 1'b0);
        end
        // R4: short displacement sign extension, and the 16-bit wrap
        issue("R4", 3'd3, 1'b0, 1'b0, 1'b0, 16'h5580, 1'b0, 1'b0, 2'd0, 1'b0);
        issue("R4", 3'd4, 1'b0, 1'b0, 1'b0, 16'h00FF, 1'b0, 1'b0, 2'd0, 1'b0);
        issue("R4", 3'd0, 1'b0, 1'b0, 1'b0, 16'hAA7F, 1'b0, 1'b0, 2'd0, 1'b0);
        @(negedge clk); #1; bx_i = 16'hFFFF; req_i = 1'b0;
        issue("R4", 3'd3, 1'b0, 1'b0, 1'b1, 16'h0002, 1'b0, 1'b0, 2'd0, 1'b0);
        // R1: 20-bit wrap
        @(negedge clk); #1; ds_i = 16'hFFFF; req_i = 1'b0;
        issue("R1", 3'd0, 1'b0, 1'b0, 1'b1, 16'h0035, 1'b0, 1'b0, 2'd0, 1'b0);
        issue("R1", 3'd6, 1'b0, 1'b1, 1'b1, 16'h8000, 1'b1, 1'b0, 2'd0, 1'b0);
        // R5: BP-based modes default to SS; BP without a base term keeps DS
        issue("R5", 3'd1, 1'b1, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, 2'd0, 1'b0);
        issue("R5", 3'd6, 1'b1, 1'b0, 1'b1, 16'h0011, 1'b0, 1'b0, 2'd0, 1'b0);
        issue("R5", 3'd2, 1'b1, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, 2'd0, 1'b0);
        // R6: string destination beats the BP rule
        issue("R6", 3'd5, 1'b1, 1'b1, 1'b1, 16'h0000, 1'b1, 1'b0, 2'd0, 1'b1);
        issue("R6", 3'd2, 1'b0, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b0, 2'd0, 1'b1);
        // R7: override beats everything
        for (int s = 0; s < 4; s++)
            issue("R7", 3'd3, 1'b1, 1'b0, 1'b0, 16'h0009, 1'b0, 1'b1, 2'(s), 1'b1);
        // R8 / R9: byte/word at even/odd
        @(negedge clk); #1; ds_i = 16'h2000; bx_i = 16'h0100; req_i = 1'b0;
        issue("R8", 3'd3, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, 2'd0, 1'b0);
        issue("R8", 3'd3, 1'b0, 1'b0, 1'b1, 16'h0001, 1'b0, 1'b0, 2'd0, 1'b0);
        issue("R9", 3'd3, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b0, 2'd0, 1'b0);
        issue("R9", 3'd3, 1'b0, 1'b0, 1'b1, 16'h0001, 1'b1, 1'b0, 2'd0, 1'b0);
        // R10: outputs hold while the request is low and the inputs change
        idle("R10");
        idle("R10");
        issue("R10", 3'd4, 1'b0, 1'b1, 1'b1, 16'h0003, 1'b1, 1'b0, 2'd0, 1'b0);
        idle("R10");
        // R11: reset applied again in mid-run
        @(negedge clk); #1; tag = "R11"; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule